// File: doc/BRIEF.md
# Four-Digit Decimal Counter with Scanned Seven-Segment Output

The block counts from 0000 to 9999 and then starts again at 0000. The count is held in four decimal (BCD) digit stages. Each stage steps only when every less significant stage wraps from 9 to 0. It runs from a single 50 MHz system clock and needs no other input besides a synchronous reset. From that clock it derives two single-cycle enables. The slow enable steps the units digit twice per second. The fast enable advances the display scan.

The display side drives one shared set of eight segment lines, which are seven segments plus a decimal point, and four digit-enable lines. Exactly one digit is enabled at a time. The segment lines carry the seven-segment pattern of whichever digit is enabled. The scan visits the units, tens, hundreds and thousands digits in that order and then repeats. With the default divider, each digit is lit 500 times per second, so the full four-digit frame also repeats at 500 Hz. That is inside the 25 Hz to 1 kHz window the display needs. Both divider lengths are parameters, so a small configuration can be exercised quickly.

There is no data stream into or out of the block. All of its pins are plain control and display lines.

Top module: `bcd4_scan_display`

## Requirements
- R1: While `rst` is high at a rising clock edge, every digit, both dividers and the scan index clear. After such an edge, `dig_n` reads 4'b1110 and `seg_n` reads 8'hC0, which is the pattern for a 0 on the units digit.
- R2: Out of reset, exactly one bit of `dig_n` is low at any time. Bit 0 of `dig_n` is units, bit 1 is tens, bit 2 is hundreds and bit 3 is thousands.
- R3: The scan index advances by one position every `SCAN_DIV` clocks, in the order units, tens, hundreds, thousands, and then repeats. After n clocks out of reset, the enabled digit is (n / `SCAN_DIV`) mod 4.
- R4: The units digit advances once every `COUNT_DIV` clocks. The default of 25,000,000 gives two steps per second at 50 MHz. After n clocks out of reset, the count is (n / `COUNT_DIV`) mod 10000.
- R5: Each digit wraps from 9 to 0. It passes a carry to the next more significant digit only on that wrap, so a digit steps only when all less significant digits wrap together.
- R6: From 9999, the next count step gives 0000.
- R7: Segment lines are active low. Bits 0 to 6 are segments a to g. Given as active-high hex values for gfedcba, the patterns are: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F. The pattern on the lines always belongs to the digit that is currently enabled, and it changes in the same cycle as the enable.
- R8: Bit 7 of `seg_n` is the decimal point, and it is always driven high, which means off.
- R9: Raising `rst` in the middle of a run takes effect on the next rising edge. Counting then restarts from 0000 with the scan back on units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, nominally 50 MHz |
| rst | input | 1 | Synchronous reset, active high |
| seg_n | output | 8 | Segment lines, active low: bits 6..0 = g..a, bit 7 = decimal point |
| dig_n | output | 4 | Digit enables, active low: bit 0 = units through bit 3 = thousands |

## Verification
Every register on the path from the clock to the pins steps on the same edge that the divider terminal count is seen. The display outputs are decoded from registers without a further stage. As a result, after n rising edges out of reset, the count is exactly n / `COUNT_DIV` and the scan position is n / `SCAN_DIV`, with no extra latency.

The bench keeps its own edge counter n and samples both outputs on the falling edge that follows each rising edge. It compares them with values computed from that formula. It sweeps the small configuration (`COUNT_DIV`=2, `SCAN_DIV`=3) through every count from 0000 to 9999 and past the wrap back to 0000. Reset takes effect on the first rising edge at which it is high, so the reset checks sample on the falling edge after that edge.

// File: rtl/bcd4_pkg.sv
package bcd4_pkg;

  typedef logic [3:0] bcd_t;
  typedef logic [6:0] seg7_t;

  // Active-high seven-segment pattern, bit 0 = segment a .. bit 6 = segment g.
  // Codes above 9 produce a blank digit.
  function automatic seg7_t bcd_to_seg(input bcd_t v);
    seg7_t s;
    case (v)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/bcd4_tick_div.sv
// Produces a single-cycle enable once every DIV clocks.
module bcd4_tick_div #(
  parameter int DIV = 25_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bcd4_digit.sv
// One decimal stage: steps when enabled and wraps from 9 to 0.
// It raises carry only on the wrap.
module bcd4_digit
  import bcd4_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic step,
  output bcd_t value,
  output logic carry
);
  bcd_t val_q;

  assign value = val_q;
  assign carry = step && (val_q == 4'd9);

  always_ff @(posedge clk) begin
    if (rst)        val_q <= '0;
    else if (carry) val_q <= '0;
    else if (step)  val_q <= val_q + 4'd1;
  end
endmodule

// File: rtl/bcd4_scan_display.sv
module bcd4_scan_display
  import bcd4_pkg::*;
#(
  parameter int COUNT_DIV  = 25_000_000,
  parameter int SCAN_DIV   = 25_000,
  parameter int NUM_DIGITS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  output logic [7:0]            seg_n,
  output logic [NUM_DIGITS-1:0] dig_n
);
  localparam int SCAN_W = (NUM_DIGITS > 2) ? $clog2(NUM_DIGITS) : 1;
  localparam logic [SCAN_W-1:0] SCAN_LAST = SCAN_W'(NUM_DIGITS - 1);

  logic count_tick;
  logic scan_tick;

  bcd4_tick_div #(.DIV(COUNT_DIV)) count_div_i (
    .clk (clk),
    .rst (rst),
    .tick(count_tick)
  );

  bcd4_tick_div #(.DIV(SCAN_DIV)) scan_div_i (
    .clk (clk),
    .rst (rst),
    .tick(scan_tick)
  );

  // Carry cascade: stage 0 is enabled by the count tick, and every later
  // stage is enabled by the wrap of the stage below it.
  logic [NUM_DIGITS:0]     step_chain;
  bcd_t                    dval [NUM_DIGITS];
  logic [4*NUM_DIGITS-1:0] digits_flat;

  assign step_chain[0] = count_tick;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    bcd4_digit digit_i (
      .clk  (clk),
      .rst  (rst),
      .step (step_chain[i]),
      .value(dval[i]),
      .carry(step_chain[i+1])
    );
    assign digits_flat[4*i +: 4] = dval[i];
  end

  // Scan position: units first, most significant last, then repeat.
  logic [SCAN_W-1:0] scan_idx;

  always_ff @(posedge clk) begin
    if (rst) scan_idx <= '0;
    else if (scan_tick) begin
      if (scan_idx == SCAN_LAST) scan_idx <= '0;
      else                       scan_idx <= scan_idx + 1'b1;
    end
  end

  // The enable and the segment pattern both decode from scan_idx,
  // so they change in the same cycle.
  bcd_t shown;

  always_comb begin
    shown = '0;
    dig_n = '1;
    for (int k = 0; k < NUM_DIGITS; k++) begin
      if (scan_idx == SCAN_W'(k)) begin
        shown    = dval[k];
        dig_n[k] = 1'b0;
      end
    end
    seg_n = {1'b1, ~bcd_to_seg(shown)};
  end

endmodule

// File: rtl/bcd4_scan_display_chk.sv
module bcd4_scan_display_chk #(
  parameter int NUM_DIGITS = 4,
  parameter int SCAN_W     = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic [7:0]              seg_n,
  input logic [NUM_DIGITS-1:0]   dig_n,
  input logic [4*NUM_DIGITS-1:0] digits,
  input logic [SCAN_W-1:0]       scan_idx,
  input logic                    count_tick,
  input logic                    scan_tick
);
  logic [NUM_DIGITS:0] lower_nine;
  logic                all_nine;
  logic                all_zero;

  always_comb begin
    lower_nine[0] = 1'b1;
    for (int k = 0; k < NUM_DIGITS; k++)
      lower_nine[k+1] = lower_nine[k] && (digits[4*k +: 4] == 4'd9);
    all_nine = lower_nine[NUM_DIGITS];
    all_zero = (digits == '0);
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (all_zero && scan_idx == '0)); // R1
  AST_ONE_DIGIT_ON: assert property (@(posedge clk) disable iff (rst) $countones(~dig_n) == 1); // R2
  AST_SCAN_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    scan_tick |=> scan_idx == (($past(scan_idx) == SCAN_W'(NUM_DIGITS-1)) ? '0 : $past(scan_idx) + 1'b1)); // R3
  AST_SCAN_HOLD: assert property (@(posedge clk) disable iff (rst) !scan_tick |=> $stable(scan_idx)); // R3
  AST_UNITS_STEP: assert property (@(posedge clk) disable iff (rst)
    count_tick |=> digits[3:0] == (($past(digits[3:0]) == 4'd9) ? 4'd0 : $past(digits[3:0]) + 4'd1)); // R4
  AST_FULL_WRAP: assert property (@(posedge clk) disable iff (rst) (count_tick && all_nine) |=> all_zero); // R6
  AST_DP_OFF: assert property (@(posedge clk) disable iff (rst) seg_n[7]); // R8

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_chk
    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst) digits[4*i +: 4] <= 4'd9); // R5
    AST_NO_CARRY_HOLD: assert property (@(posedge clk) disable iff (rst)
      !(count_tick && lower_nine[i]) |=> $stable(digits[4*i +: 4])); // R5
    AST_CARRY_STEP: assert property (@(posedge clk) disable iff (rst)
      (count_tick && lower_nine[i]) |=> !$stable(digits[4*i +: 4])); // R5
  end
endmodule

bind bcd4_scan_display bcd4_scan_display_chk #(
  .NUM_DIGITS(NUM_DIGITS),
  .SCAN_W    (SCAN_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .seg_n     (seg_n),
  .dig_n     (dig_n),
  .digits    (digits_flat),
  .scan_idx  (scan_idx),
  .count_tick(count_tick),
  .scan_tick (scan_tick)
);

// File: tb/bcd4_scan_display_tb_top.sv
module bcd4_scan_display_tb_top;
  localparam int CLK_PERIOD = 20;
  localparam int CDIV       = 2;
  localparam int SDIV       = 3;
  localparam int SWEEP      = 10000 * CDIV + 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] seg_n;
  logic [3:0] dig_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd4_scan_display #(
    .COUNT_DIV (CDIV),
    .SCAN_DIV  (SDIV),
    .NUM_DIGITS(4)
  ) dut_i (
    .clk  (clk),
    .rst  (rst),
    .seg_n(seg_n),
    .dig_n(dig_n)
  );

  // Expected active-high gfedcba pattern, from the table in R7.
  function automatic logic [6:0] exp_pat(input int d);
    case (d)
      0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
      4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
      8: return 7'h7F;  default: return 7'h6F;
    endcase
  endfunction

  task automatic check_at(input int n, input string tag);
    int cnt, pos, dval, p10;
    logic [3:0] edig;
    logic [7:0] eseg;
    cnt  = (n / CDIV) % 10000;
    pos  = (n / SDIV) % 4;
    p10  = 1;
    for (int k = 0; k < pos; k++) p10 = p10 * 10;
    dval = (cnt / p10) % 10;
    edig = ~(4'b0001 << pos);
    eseg = {1'b1, ~exp_pat(dval)};
    checks++;
    if (dig_n !== edig) begin
      fails++;
      $display("FAIL %s/R2/R3 n=%0d dig_n actual=%b expected=%b", tag, n, dig_n, edig);
    end
    checks++;
    if (seg_n !== eseg) begin
      fails++;
      $display("FAIL %s/R7/R8 n=%0d count=%0d seg_n actual=%h expected=%h", tag, n, cnt, seg_n, eseg);
    end
  endtask

  function automatic string tag_for(input int n);
    int cnt = (n / CDIV) % 10000;
    if (n >= CDIV && cnt == 0)                   return "R6";
    if (n >= CDIV && cnt % 10 == 0 && cnt != 0)  return "R5";
    return "R4";
  endfunction

  initial begin
    // R1: state after reset edges
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_at(0, "R1");
    rst = 1'b0;
    // Full sweep through 9999 and the wrap (R4, R5, R6)
    for (int n = 1; n <= SWEEP; n++) begin
      @(posedge clk);
      @(negedge clk);
      check_at(n, tag_for(n));
    end
    // R9: synchronous reset mid-run
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_at(0, "R9");
    @(posedge clk);
    @(negedge clk);
    check_at(0, "R9");
    rst = 1'b0;
    for (int n = 1; n <= 40; n++) begin
      @(posedge clk);
      @(negedge clk);
      check_at(n, "R9");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule